// File: doc/BRIEF.md
# Pass-Through Holding Register with Per-Byte Tracking

This block is a 32-bit staging register placed between a host-bus target and a narrower local peripheral bus. When the host side opens a data phase, the block records which byte lanes the host transfer covers in a mask of pending flags, and it raises an attention output. On a host write, the local side reads the bytes out. On a host read, the local side writes the bytes in. Every byte is retired on its own, in any order, when the local side selects it while it is still pending.

The local bus can run 8, 16 or 32 bits wide, chosen by a mode input. In the narrow modes, the selected lane or lane pair is steered onto the low bits of the local data bus in both directions. The data phase ends only when the local side pulls its ready line low. At that point the attention output drops and any leftover pending flags are cleared. The register then accepts the next host transfer.

Top module: `ptx_hold_reg`

## Requirements
- R1: After reset, `attn` is 0, `lane_pend` is all zeros, `phase_done` is 0 and the register (`host_rdata`) is zero.
- R2: A `host_load` pulse while `attn` is 0 sets `attn` at the next edge and loads `lane_pend[i]` with the inverse of `host_be_n[i]`. Bit i is lane i, which is bits 8i+7:8i. When `host_wr` is 1, each lane with `host_be_n[i]`=0 also takes lane i of `host_wdata`. When `host_wr` is 0, the register keeps its contents.
- R3: A `host_load` pulse while `attn` is 1 has no effect on the register, the pending mask or the phase direction.
- R4: At each edge with `attn` high, a lane whose pending flag is set and whose `loc_be_n` bit is 0 has its pending flag cleared. All other pending flags are unchanged. Lanes may be retired in any order.
- R5: In a phase opened with `host_wr`=0, lane i of the register is written from the local bus only at an edge where `lane_pend[i]`=1 and `loc_be_n[i]`=0. In a phase opened with `host_wr`=1, the local side never changes the register.
- R6: In 8-bit mode (`bus_mode`=00), `loc_rdata[7:0]` shows the lowest-numbered lane whose `loc_be_n` bit is 0. All other bits read 0, and all bits read 0 when no lane is enabled.
- R7: In 16-bit mode (`bus_mode`=01), the lowest lane pair {2p+1,2p} that has an enabled lane drives `loc_rdata[15:0]`. Lane 2p goes to bits 7:0 and lane 2p+1 to bits 15:8, and each half is 0 if its own enable is high. Bits above 15 read 0.
- R8: In 32-bit mode (`bus_mode`=10 or 11), lane i of `loc_rdata` equals register lane i when `loc_be_n[i]`=0 and reads 0 otherwise.
- R9: Local write data is steered into lanes as follows. In 8-bit mode, every lane takes `loc_wdata[7:0]`. In 16-bit mode, lane i takes `loc_wdata[8*(i%2)+7:8*(i%2)]`. In 32-bit mode, lane i takes `loc_wdata[8i+7:8i]`.
- R10: At an edge with `attn` high and `loc_rdy_n` low, `attn` falls, every pending flag clears (including leftover ones) and `phase_done` is 1 for exactly the following cycle.
- R11: `loc_rdata` follows `loc_be_n` combinationally, so a lane stays on the bus for as long as its enable is held, even after the lane has been retired. While `attn` is 0, local enables and data change neither the register nor the pending mask.
- R12: After a phase closes, a new host load is visible on `host_rdata` and `loc_rdata` in the cycle after the load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_load | input | 1 | Pulse that opens a data phase |
| host_wr | input | 1 | 1: host write (local side drains); 0: host read (local side fills) |
| host_be_n | input | 4 | Host byte enables, active low, bit i = lane i |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Register contents |
| bus_mode | input | 2 | Local bus width: 00 8-bit, 01 16-bit, 1x 32-bit |
| loc_be_n | input | 4 | Local lane enables, active low |
| loc_wdata | input | 32 | Local write data |
| loc_rdata | output | 32 | Steered local read data |
| loc_rdy_n | input | 1 | Local ready, active low; closes the phase |
| lane_pend | output | 4 | Pending-byte mask, bit i = lane i |
| attn | output | 1 | High while a data phase is open |
| phase_done | output | 1 | One-cycle pulse after the phase closes |

## Verification
Read steering is driven from one table that covers each single-lane enable, several multi-lane enables and the all-off value in every width mode. This separates lowest-lane priority in 8-bit mode from pair selection in 16-bit mode and from per-lane masking in 32-bit mode. Local fills use a lane order that is not sequential, repeat a write to a lane that is already retired, and apply an all-lane write where only some lanes are pending. This shows that the pending mask gates the writes, not the enables alone. Partial host loads, a load issued while a phase is open, a ready given while bytes are still pending, and local activity outside a phase each test a separate rule for opening or closing a phase.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
   localparam int LANE_W = 8;

   typedef enum logic [1:0] {
      BUS_X8      = 2'b00,
      BUS_X16     = 2'b01,
      BUS_X32     = 2'b10,
      BUS_X32_ALT = 2'b11
   } bus_mode_e;
endpackage

// File: rtl/ptx_phase_ctl.sv
module ptx_phase_ctl #(
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             host_wr_i,
   input  logic [LANES-1:0] host_be_n_i,
   input  logic [LANES-1:0] loc_be_n_i,
   input  logic             rdy_n_i,
   output logic             attn_o,
   output logic             fwd_o,
   output logic             load_fire_o,
   output logic [LANES-1:0] pend_o,
   output logic [LANES-1:0] retire_o,
   output logic             done_o
);
   logic             attn_q, fwd_q, done_q;
   logic [LANES-1:0] pend_q, pend_d, retire;
   logic             load_fire, close_fire;

   assign load_fire  = load_i & ~attn_q;
   assign close_fire = attn_q & ~rdy_n_i;
   assign retire     = attn_q ? (pend_q & ~loc_be_n_i) : '0;

   always_comb begin
      pend_d = pend_q;
      if (load_fire)
         pend_d = ~host_be_n_i;
      else if (close_fire)
         pend_d = '0;
      else
         pend_d = pend_q & ~retire;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         attn_q <= 1'b0;
         fwd_q  <= 1'b0;
         done_q <= 1'b0;
         pend_q <= '0;
      end else begin
         pend_q <= pend_d;
         done_q <= close_fire;
         if (load_fire) begin
            attn_q <= 1'b1;
            fwd_q  <= host_wr_i;
         end else if (close_fire) begin
            attn_q <= 1'b0;
         end
      end
   end

   assign attn_o      = attn_q;
   assign fwd_o       = fwd_q;
   assign load_fire_o = load_fire;
   assign pend_o      = pend_q;
   assign retire_o    = retire;
   assign done_o      = done_q;

   // R2: opening a phase raises attention and copies the host enables
   assert_phase_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !attn_q) |=> (attn_q && (pend_q == ~$past(host_be_n_i))));

   // R4: during an open phase no pending flag can reappear
   assert_no_new_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
      attn_q |=> ((pend_q & ~$past(pend_q)) == '0));

   // R10: no pending byte survives outside a phase
   assert_idle_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !attn_q |-> (pend_q == '0));

   // R10: ready closes the phase and pulses done
   assert_close_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (attn_q && !rdy_n_i) |=> (!attn_q && done_o));

   // R10: done lasts a single cycle
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
endmodule

// File: rtl/ptx_wr_steer.sv
module ptx_wr_steer #(
   parameter int LANES = 4
) (
   input  logic [1:0]                      mode_i,
   input  logic [LANES*ptx_pkg::LANE_W-1:0] wdata_i,
   output logic [LANES*ptx_pkg::LANE_W-1:0] lanes_o
);
   import ptx_pkg::*;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int PAIR_OFS = (i % 2) * LANE_W;
      always_comb begin
         case (bus_mode_e'(mode_i))
            BUS_X8:  lanes_o[i*LANE_W +: LANE_W] = wdata_i[LANE_W-1:0];
            BUS_X16: lanes_o[i*LANE_W +: LANE_W] = wdata_i[PAIR_OFS +: LANE_W];
            default: lanes_o[i*LANE_W +: LANE_W] = wdata_i[i*LANE_W +: LANE_W];
         endcase
      end
   end
endmodule

// File: rtl/ptx_rd_steer.sv
module ptx_rd_steer #(
   parameter int LANES = 4
) (
   input  logic [1:0]                      mode_i,
   input  logic [LANES-1:0]                be_n_i,
   input  logic [LANES*ptx_pkg::LANE_W-1:0] data_i,
   output logic [LANES*ptx_pkg::LANE_W-1:0] rdata_o
);
   import ptx_pkg::*;

   localparam int PAIRS = LANES / 2;

   logic [LANES*LANE_W-1:0] x8_out, x16_out, x32_out;

   always_comb begin
      logic found8;
      found8 = 1'b0;
      x8_out = '0;
      for (int i = 0; i < LANES; i++) begin
         if (!found8 && !be_n_i[i]) begin
            x8_out[LANE_W-1:0] = data_i[i*LANE_W +: LANE_W];
            found8 = 1'b1;
         end
      end
   end

   always_comb begin
      logic found16;
      found16 = 1'b0;
      x16_out = '0;
      for (int p = 0; p < PAIRS; p++) begin
         if (!found16 && (!be_n_i[2*p] || !be_n_i[2*p+1])) begin
            x16_out[LANE_W-1:0] =
               be_n_i[2*p]   ? '0 : data_i[(2*p)*LANE_W +: LANE_W];
            x16_out[2*LANE_W-1:LANE_W] =
               be_n_i[2*p+1] ? '0 : data_i[(2*p+1)*LANE_W +: LANE_W];
            found16 = 1'b1;
         end
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_x32
      assign x32_out[i*LANE_W +: LANE_W] =
         be_n_i[i] ? '0 : data_i[i*LANE_W +: LANE_W];
   end

   always_comb begin
      case (bus_mode_e'(mode_i))
         BUS_X8:  rdata_o = x8_out;
         BUS_X16: rdata_o = x16_out;
         default: rdata_o = x32_out;
      endcase
   end
endmodule

// File: rtl/ptx_lane_store.sv
module ptx_lane_store #(
   parameter int LANES = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            load_fire_i,
   input  logic                            host_wr_i,
   input  logic [LANES-1:0]                host_be_n_i,
   input  logic [LANES*ptx_pkg::LANE_W-1:0] host_wdata_i,
   input  logic                            fwd_i,
   input  logic [LANES-1:0]                retire_i,
   input  logic [LANES*ptx_pkg::LANE_W-1:0] loc_lanes_i,
   output logic [LANES*ptx_pkg::LANE_W-1:0] data_o
);
   import ptx_pkg::*;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] lane_q;
      logic              host_we, loc_we;

      assign host_we = load_fire_i & host_wr_i & ~host_be_n_i[i];
      assign loc_we  = retire_i[i] & ~fwd_i;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lane_q <= '0;
         else if (host_we)
            lane_q <= host_wdata_i[i*LANE_W +: LANE_W];
         else if (loc_we)
            lane_q <= loc_lanes_i[i*LANE_W +: LANE_W];
      end

      assign data_o[i*LANE_W +: LANE_W] = lane_q;
   end
endmodule

// File: rtl/ptx_hold_reg.sv
module ptx_hold_reg #(
   parameter int LANES = 4,
   localparam int W    = LANES * ptx_pkg::LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_load,
   input  logic             host_wr,
   input  logic [LANES-1:0] host_be_n,
   input  logic [W-1:0]     host_wdata,
   output logic [W-1:0]     host_rdata,
   input  logic [1:0]       bus_mode,
   input  logic [LANES-1:0] loc_be_n,
   input  logic [W-1:0]     loc_wdata,
   output logic [W-1:0]     loc_rdata,
   input  logic             loc_rdy_n,
   output logic [LANES-1:0] lane_pend,
   output logic             attn,
   output logic             phase_done
);
   import ptx_pkg::*;

   if (LANES < 2 || (LANES % 2) != 0) begin : g_bad_lanes
      $error("ptx_hold_reg: LANES must be even and at least 2");
   end

   logic             fwd, load_fire;
   logic [LANES-1:0] retire;
   logic [W-1:0]     loc_lanes, reg_data;

   ptx_phase_ctl #(.LANES(LANES)) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (host_load),
      .host_wr_i   (host_wr),
      .host_be_n_i (host_be_n),
      .loc_be_n_i  (loc_be_n),
      .rdy_n_i     (loc_rdy_n),
      .attn_o      (attn),
      .fwd_o       (fwd),
      .load_fire_o (load_fire),
      .pend_o      (lane_pend),
      .retire_o    (retire),
      .done_o      (phase_done)
   );

   ptx_wr_steer #(.LANES(LANES)) u_wr (
      .mode_i  (bus_mode),
      .wdata_i (loc_wdata),
      .lanes_o (loc_lanes)
   );

   ptx_lane_store #(.LANES(LANES)) u_store (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_fire_i  (load_fire),
      .host_wr_i    (host_wr),
      .host_be_n_i  (host_be_n),
      .host_wdata_i (host_wdata),
      .fwd_i        (fwd),
      .retire_i     (retire),
      .loc_lanes_i  (loc_lanes),
      .data_o       (reg_data)
   );

   ptx_rd_steer #(.LANES(LANES)) u_rd (
      .mode_i  (bus_mode),
      .be_n_i  (loc_be_n),
      .data_i  (reg_data),
      .rdata_o (loc_rdata)
   );

   assign host_rdata = reg_data;

   // R5: during a host-write phase the local side cannot alter the register
   assert_fwd_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (attn && fwd) |=> $stable(host_rdata));

   // R11: outside a phase only a host load may change the register
   assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!attn && !host_load) |=> $stable(host_rdata));

   // R6: 8-bit mode leaves every bit above the low byte at zero
   assert_x8_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_mode == BUS_X8) |-> (loc_rdata[W-1:LANE_W] == '0));

   // R7: 16-bit mode leaves every bit above the low half-word at zero
   assert_x16_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_mode == BUS_X16) |-> ((loc_rdata >> (2*LANE_W)) == '0));
endmodule

// File: tb/ptx_hold_reg_test.sv
module ptx_hold_reg_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_load = 1'b0;
   logic        host_wr = 1'b1;
   logic [3:0]  host_be_n = 4'hF;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic [1:0]  bus_mode = 2'b10;
   logic [3:0]  loc_be_n = 4'hF;
   logic [31:0] loc_wdata = '0;
   logic [31:0] loc_rdata;
   logic        loc_rdy_n = 1'b1;
   logic [3:0]  lane_pend;
   logic        attn;
   logic        phase_done;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   ptx_hold_reg uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_load  (host_load),
      .host_wr    (host_wr),
      .host_be_n  (host_be_n),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .bus_mode   (bus_mode),
      .loc_be_n   (loc_be_n),
      .loc_wdata  (loc_wdata),
      .loc_rdata  (loc_rdata),
      .loc_rdy_n  (loc_rdy_n),
      .lane_pend  (lane_pend),
      .attn       (attn),
      .phase_done (phase_done)
   );

   // {mode, loc_be_n, expected loc_rdata} with register = C3A55E17
   localparam logic [37:0] RD_VEC [16] = '{
      {2'b00, 4'hE, 32'h0000_0017},   // R6 lane 0
      {2'b00, 4'hD, 32'h0000_005E},   // R6 lane 1
      {2'b00, 4'hB, 32'h0000_00A5},   // R6 lane 2
      {2'b00, 4'h7, 32'h0000_00C3},   // R6 lane 3
      {2'b00, 4'h3, 32'h0000_00A5},   // R6 lowest of lanes 2,3
      {2'b00, 4'hF, 32'h0000_0000},   // R6 none
      {2'b01, 4'hC, 32'h0000_5E17},   // R7 low pair
      {2'b01, 4'h3, 32'h0000_C3A5},   // R7 high pair
      {2'b01, 4'hE, 32'h0000_0017},   // R7 lane 0 only
      {2'b01, 4'hD, 32'h0000_5E00},   // R7 lane 1 only
      {2'b01, 4'h7, 32'h0000_C300},   // R7 lane 3 only
      {2'b01, 4'hF, 32'h0000_0000},   // R7 none
      {2'b10, 4'h0, 32'hC3A5_5E17},   // R8 all
      {2'b10, 4'h5, 32'hC300_5E00},   // R8 lanes 1,3
      {2'b10, 4'hF, 32'h0000_0000},   // R8 none
      {2'b11, 4'h0, 32'hC3A5_5E17}    // R8 alternate code
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic host_open(input logic wr, input logic [3:0] be_n, input logic [31:0] d);
      host_wr    = wr;
      host_be_n  = be_n;
      host_wdata = d;
      host_load  = 1'b1;
      step();
      host_load  = 1'b0;
      host_be_n  = 4'hF;
   endtask

   task automatic close_phase();
      loc_be_n  = 4'hF;
      loc_rdy_n = 1'b0;
      step();
      loc_rdy_n = 1'b1;
   endtask

   initial begin
      #(4 * 200000);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();

      // R1 reset state
      check("R1 attn", {31'd0, attn}, 32'd0);
      check("R1 pend", {28'd0, lane_pend}, 32'd0);
      check("R1 done", {31'd0, phase_done}, 32'd0);
      check("R1 data", host_rdata, 32'd0);
      loc_be_n = 4'h0;
      #1;
      check("R1 loc_rdata", loc_rdata, 32'd0);
      loc_be_n = 4'hF;

      // R2 partial host write opens a phase
      host_open(1'b1, 4'b1010, 32'h1122_3344);
      check("R2 attn", {31'd0, attn}, 32'd1);
      check("R2 pend", {28'd0, lane_pend}, 32'h5);
      check("R2 data", host_rdata, 32'h0022_0044);

      // R3 load while open is ignored
      host_open(1'b0, 4'b0000, 32'hFFFF_FFFF);
      check("R3 pend", {28'd0, lane_pend}, 32'h5);
      check("R3 data", host_rdata, 32'h0022_0044);

      // R4 retire lane 2 first, then lane 0
      loc_be_n = 4'b1011;
      step();
      check("R4 pend after lane2", {28'd0, lane_pend}, 32'h1);
      loc_be_n = 4'b1110;
      step();
      check("R4 pend after lane0", {28'd0, lane_pend}, 32'h0);
      check("R4 attn still open", {31'd0, attn}, 32'd1);
      check("R5 host-write phase data", host_rdata, 32'h0022_0044);

      // R10 close
      close_phase();
      check("R10 attn", {31'd0, attn}, 32'd0);
      check("R10 done", {31'd0, phase_done}, 32'd1);
      step();
      check("R10 done one cycle", {31'd0, phase_done}, 32'd0);

      // R12 new data after close
      host_open(1'b1, 4'b0000, 32'hC3A5_5E17);
      check("R12 data", host_rdata, 32'hC3A5_5E17);
      check("R12 pend", {28'd0, lane_pend}, 32'hF);

      // R6 R7 R8 steering table
      for (int k = 0; k < 16; k++) begin
         bus_mode = RD_VEC[k][37:36];
         loc_be_n = RD_VEC[k][35:32];
         #1;
         check($sformatf("R6/R7/R8 vector %0d", k), loc_rdata, RD_VEC[k][31:0]);
         step();
      end
      close_phase();

      // R5 R9 host-read phase, local fills
      host_open(1'b0, 4'b0000, 32'h0);
      check("R2 host read keeps data", host_rdata, 32'hC3A5_5E17);
      check("R2 host read pend", {28'd0, lane_pend}, 32'hF);
      bus_mode  = 2'b00;
      loc_be_n  = 4'b1101;
      loc_wdata = 32'h0000_00AB;
      step();
      check("R9 x8 write lane1", host_rdata, 32'hC3A5_AB17);
      check("R4 pend x8", {28'd0, lane_pend}, 32'hD);
      loc_wdata = 32'h0000_00CD;
      step();
      check("R5 retired lane not rewritten", host_rdata, 32'hC3A5_AB17);
      bus_mode  = 2'b01;
      loc_be_n  = 4'b0111;
      loc_wdata = 32'h0000_9900;
      step();
      check("R9 x16 write lane3", host_rdata, 32'h99A5_AB17);
      check("R4 pend x16", {28'd0, lane_pend}, 32'h5);
      bus_mode  = 2'b10;
      loc_be_n  = 4'b0000;
      loc_wdata = 32'h4433_2211;
      step();
      check("R5 R9 x32 only pending lanes", host_rdata, 32'h9933_AB11);
      check("R4 pend drained", {28'd0, lane_pend}, 32'h0);

      // R11 stretched access keeps lane on the bus
      bus_mode = 2'b00;
      loc_be_n = 4'b1110;
      for (int k = 0; k < 3; k++) begin
         #1;
         check("R11 stretched lane0", loc_rdata, 32'h0000_0011);
         step();
      end
      close_phase();

      // R10 leftover pending flags cleared by ready
      host_open(1'b1, 4'b0011, 32'hAABB_CCDD);
      check("R2 partial upper lanes", host_rdata, 32'hAABB_AB11);
      check("R2 pend upper", {28'd0, lane_pend}, 32'hC);
      close_phase();
      check("R10 leftover attn", {31'd0, attn}, 32'd0);
      check("R10 leftover pend", {28'd0, lane_pend}, 32'h0);
      check("R10 leftover done", {31'd0, phase_done}, 32'd1);

      // R11 local activity outside a phase has no effect
      bus_mode  = 2'b10;
      loc_be_n  = 4'h0;
      loc_wdata = 32'h0;
      step();
      step();
      check("R11 idle data", host_rdata, 32'hAABB_AB11);
      check("R11 idle pend", {28'd0, lane_pend}, 32'h0);
      check("R11 idle loc_rdata", loc_rdata, 32'hAABB_AB11);
      loc_rdy_n = 1'b0;
      step();
      check("R10 ready outside phase", {31'd0, phase_done}, 32'd0);
      loc_rdy_n = 1'b1;

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule